// File: doc/BRIEF.md
# Push-Button Light Switch with Idle Timeout

This controller turns a single push button into a toggling light switch that switches itself off after a set number of idle rounds. Each rising clock edge is one round. In that round the controller samples the button level, takes exactly one transition, and updates a registered light output. The light shows whether the switch is in its lit mode.

The switch has two modes, dark and lit. It also has an idle counter that runs only while the switch is lit. A press in the dark mode lights the lamp and leaves the counter at zero. A press while lit turns the lamp off. If no press comes while the switch is lit, the counter climbs one step per round up to a limit. The round after the counter reaches that limit, the switch goes dark. Whenever the switch goes dark the counter is cleared. With no presses, a lit period therefore lasts TIMEOUT+1 rounds.

The limit is a compile-time parameter. There is no data stream in or out: the button and the light are plain control pins and take no handshake. An active-high synchronous reset returns the switch to dark with the counter at zero.

Top module: `tsw_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is dark with the counter at zero and `light_o` at 0, whatever the level of `press_i`.
- R2: In the dark mode, a round with `press_i` = 0 leaves the switch dark.
- R3: In the dark mode, a round with `press_i` = 1 makes the switch lit, and the idle counter starts from zero.
- R4: In the lit mode, a round with `press_i` = 0 while the counter is below TIMEOUT keeps the switch lit and adds one to the counter.
- R5: In the lit mode, a round with `press_i` = 1 makes the switch dark and clears the counter.
- R6: In the lit mode, a round in which the counter already equals TIMEOUT makes the switch dark and clears the counter. With no press, `light_o` stays 1 for exactly TIMEOUT+1 consecutive rounds.
- R7: When a press and counter expiry fall in the same round, the switch takes one transition only and ends up dark.
- R8: With `press_i` held at 1, the mode alternates between lit and dark every round.
- R9: `light_o` is registered. It is 1 exactly when the mode is lit, and it changes only at the clock edge that samples the press.
- R10: The idle counter never exceeds TIMEOUT and is zero whenever the switch is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Round clock; each rising edge is one round |
| rst | input | 1 | Active-high synchronous reset |
| press_i | input | 1 | Button level sampled each round |
| light_o | output | 1 | Registered lamp drive, 1 while lit |

## Verification
Two pairs of functions can land in the same round. The first is a button press and the idle expiry: the bench presses again after every possible count of idle rounds, including the round in which the counter sits at its limit. A per-round reference model then judges that the switch ends dark rather than flipping twice. The second is reset and press: the bench asserts reset with the button held during a lit period and expects the lamp to be dark afterwards.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic {
    MODE_DARK = 1'b0,
    MODE_LIT  = 1'b1
  } mode_e;
endpackage

// File: rtl/tsw_step.sv
module tsw_step
  import tsw_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  mode_e          mode_q,
  input  logic           press,
  input  logic           at_limit,
  output mode_e          mode_d,
  output logic           cnt_clr,
  output logic           cnt_inc
);
  // One transition per round; the mode decides which guards apply.
  always_comb begin
    mode_d  = mode_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (mode_q)
      MODE_DARK: begin
        if (press) mode_d = MODE_LIT;
      end
      MODE_LIT: begin
        if (press || at_limit) begin
          mode_d  = MODE_DARK;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: mode_d = MODE_DARK;
    endcase
  end

  // Clear and increment never requested together (R7: single transition)
  always_comb begin
    assert (!(cnt_clr && cnt_inc)) else $error("AST_ONE_ACTION"); // R7
  end
endmodule

// File: rtl/tsw_idle_cnt.sv
module tsw_idle_cnt #(
  parameter int unsigned TIMEOUT = 10,
  parameter int unsigned CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_o,
  output logic          at_limit_o
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q < LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q >= LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT) else $error("AST_CNT_BOUND"); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt_q < LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("AST_CNT_STEP"); // R4

  AST_CNT_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)) else $error("AST_CNT_CLR"); // R5
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int unsigned TIMEOUT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic press_i,
  output logic light_o
);
  localparam int unsigned CW = (TIMEOUT < 1) ? 1 : $clog2(TIMEOUT + 1);

  mode_e         mode_q, mode_d;
  logic          cnt_clr, cnt_inc, at_limit;
  logic [CW-1:0] cnt;
  logic          light_q;

  tsw_step #(.CW(CW)) u_step (
    .mode_q  (mode_q),
    .press   (press_i),
    .at_limit(at_limit),
    .mode_d  (mode_d),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc)
  );

  tsw_idle_cnt #(.TIMEOUT(TIMEOUT), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clr),
    .inc       (cnt_inc),
    .cnt_o     (cnt),
    .at_limit_o(at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_DARK;
      light_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      light_q <= (mode_d == MODE_LIT);
    end
  end

  assign light_o = light_q;

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (mode_q == MODE_DARK && cnt == '0 && !light_o))
    else $error("AST_RESET_DARK"); // R1

  AST_DARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DARK && !press_i) |=> (mode_q == MODE_DARK))
    else $error("AST_DARK_HOLD"); // R2

  AST_DARK_TO_LIT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DARK && press_i) |=> (mode_q == MODE_LIT && cnt == '0))
    else $error("AST_DARK_TO_LIT"); // R3

  AST_LIT_PRESS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LIT && press_i) |=> (mode_q == MODE_DARK))
    else $error("AST_LIT_PRESS"); // R5

  AST_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LIT && cnt == CW'(TIMEOUT)) |=> (mode_q == MODE_DARK))
    else $error("AST_EXPIRE"); // R6

  AST_DARK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DARK) |-> (cnt == '0)) else $error("AST_DARK_ZERO"); // R10

  AST_LIGHT_MATCH: assert property (@(posedge clk) disable iff (rst)
    light_o == (mode_q == MODE_LIT)) else $error("AST_LIGHT_MATCH"); // R9
endmodule

// File: tb/tsw_ctrl_tb_top.sv
module tsw_ctrl_tb_top;
  localparam int unsigned TO = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic press_i = 1'b0;
  logic light_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference state
  bit ref_lit = 1'b0;
  int ref_x   = 0;

  always #5 clk = ~clk;

  tsw_ctrl #(.TIMEOUT(TO)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .press_i(press_i),
    .light_o(light_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: light_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // One round: drive at negedge, model the edge, compare at next negedge.
  task automatic round(input logic p, input logic r, input string force_tag);
    string tag;
    press_i = p;
    rst     = r;
    if (r)                             tag = "R1";
    else if (!ref_lit && !p)           tag = "R2";
    else if (!ref_lit && p)            tag = "R3";
    else if (p && ref_x >= int'(TO))   tag = "R7";
    else if (p)                        tag = "R5";
    else if (ref_x >= int'(TO))        tag = "R6";
    else                               tag = "R4";
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    if (r) begin
      ref_lit = 1'b0; ref_x = 0;
    end else if (!ref_lit) begin
      if (p) ref_lit = 1'b1;
    end else if (p || ref_x >= int'(TO)) begin
      ref_lit = 1'b0; ref_x = 0;
    end else begin
      ref_x++;
    end
    @(negedge clk);
    check(light_o, ref_lit, tag);
  endtask

  initial begin
    @(negedge clk);
    round(1'b0, 1'b1, "R1");
    round(1'b1, 1'b1, "R1");            // reset beats press
    for (int i = 0; i < 3; i++) round(1'b0, 1'b0, "");   // R2

    // R9: a press does not show before the sampling edge
    press_i = 1'b1;
    #2;
    check(light_o, 1'b0, "R9");
    round(1'b1, 1'b0, "R3");
    // R6/R10: idle until expiry; lit lasts TO+1 rounds
    for (int i = 0; i < int'(TO) + 3; i++) round(1'b0, 1'b0, "");

    // sweep a second press over every idle count, incl. expiry round (R5, R7)
    for (int d = 0; d <= int'(TO) + 1; d++) begin
      round(1'b1, 1'b0, "");
      for (int k = 0; k < d; k++) round(1'b0, 1'b0, "");
      round(1'b1, 1'b0, "");
      for (int k = 0; k < int'(TO) + 2; k++) round(1'b0, 1'b0, "");
    end

    // R8: held press toggles every round
    for (int i = 0; i < 8; i++) round(1'b1, 1'b0, "R8");
    for (int i = 0; i < int'(TO) + 2; i++) round(1'b0, 1'b0, "");

    // R1: reset in the middle of a lit period, button held
    round(1'b1, 1'b0, "");
    for (int i = 0; i < 2; i++) round(1'b0, 1'b0, "");
    round(1'b1, 1'b1, "R1");
    for (int i = 0; i < 3; i++) round(1'b0, 1'b0, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule